// File: doc/BRIEF.md
# SD Host Transmit Data Path

This block is the card-bound half of an SD host data engine. A DMA engine or an interrupt handler pushes 32-bit words into a 32-entry transmit FIFO. Once the path is enabled, it waits for the FIFO to hold a word. It then sends the transfer to the card as one or more blocks on a 4-bit data bus. Each block is followed by a per-line CRC16 and an end bit.

A word counter tracks how much of the transfer is still unsent. Before each block the path holds off while the card pulls DAT0 low. It reports the end of each block, the end of the whole transfer, and a FIFO underrun. An underrun stops the path.

The refill request asks for service when at least eight FIFO slots are free. It is also qualified by the number of words the transfer still needs. A handler that writes eight words per request therefore never fetches beyond the end of its buffer.

Top module: `sdTxPath`

## Requirements
- R1: The FIFO holds 32 words. A write is taken only while `en` is high, the FIFO is not full and the transfer still owes words. While `en` is low the FIFO is emptied, so no word written before enable is ever sent.
- R2: `dataReq` is high exactly when `en` is high, at least 8 FIFO slots are free, and fewer words have been accepted than `xferWords`. A handler writing 8 words per request (fewer on the last) therefore needs ceil(xferWords/8) requests, which is 16 for a 512-byte transfer.
- R3: After enable, a block starts on the first cycle that finds the FIFO non-empty and `dat0In` high. Data leaves on `datOut` one nibble per cycle, with `datOe` high. Each word is sent most-significant nibble first, and bit l of the nibble drives data line l.
- R4: `blkSizeCode` n selects a block of 2^n bytes, so code 9 selects 512 bytes. That is 2^(n-2) words, or 1 word for n below 2. The transfer length is `xferWords` words, and the last block is shortened if the length is not a whole number of blocks.
- R5: After each block's data, the path sends 16 CRC cycles. Line l carries its own CRC16 (polynomial x^16+x^12+x^5+1, initial value zero) over the bits it carried in that block, most-significant bit first. One all-ones end-bit cycle follows. `blockEnd` is high during exactly that end-bit cycle.
- R6: `dataCount` is loaded with `xferWords` while disabled and drops by one per word sent. After the final end bit, `dataEnd` goes high with `dataCount` at zero and stays high until `en` falls.
- R7: If `dat0In` is low when a block is due to start (at enable or after an end bit), nothing is sent until `dat0In` is high again. `dat0In` is not examined inside a block.
- R8: If the next word of a block is needed and the FIFO is empty, `underrun` goes high and stays high until disable. `datOe` drops, nothing more is sent, and `dataCount` keeps the number of unsent words.
- R9: `txActive` is high from enable until the final end bit has been sent or an underrun has occurred, and is low while disabled. Whenever `datOe` is low, `datOut` reads 4'hF.
- R10: After reset, all status outputs are low, `datOe` is low and `datOut` is 4'hF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Data path enable; low clears the FIFO and reloads the counters |
| blkSizeCode | input | 4 | Block size as log2 of bytes |
| xferWords | input | LEN_W | Transfer length in words, held stable while enabled |
| wrEn | input | 1 | FIFO write strobe |
| wrData | input | WORD_W | FIFO write word |
| dat0In | input | 1 | Card DAT0 level; low means busy |
| dataReq | output | 1 | Qualified half-empty refill request |
| datOut | output | 4 | Card data lines |
| datOe | output | 1 | Data line drive enable |
| txActive | output | 1 | Transfer in progress |
| blockEnd | output | 1 | End-bit cycle of a block |
| dataEnd | output | 1 | Whole transfer sent |
| underrun | output | 1 | FIFO ran empty inside a block |
| dataCount | output | LEN_W | Words not yet sent |

## Verification
A wrong word counter shows up directly on `dataCount`, and within one block as a CRC phase that comes a word early or late, or as a missing `dataEnd`. A fault in the nibble shift or the per-line CRC corrupts the captured line stream in the cycle it occurs, so every transfer's stream is rebuilt nibble by nibble and compared. A fault in the request qualifier changes the number of refill requests a fixed-size handler makes, which the 512-byte case counts exactly. Faults in the busy gate or the underrun path show within a few cycles as drive on `datOe` where none is allowed, or as an underrun that never stops the lines.

// File: rtl/sdTxPkg.sv
package sdTxPkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_SEND, ST_CRC, ST_END, ST_DONE, ST_FAULT
  } txState_e;

  typedef struct packed {
    logic startBlk;   // begin a block: pop first word, clear CRC, load block count
    logic loadWord;   // pop FIFO head into the shifter
    logic shiftNib;   // send one nibble and fold it into the CRCs
    logic wordDone;   // last nibble of a word leaves this cycle
    logic shiftCrc;   // send one CRC bit per line
    logic clrCnt;     // restart the phase counter
  } txStrobe_t;
endpackage

// File: rtl/sdTxDatapath.sv
module sdTxDatapath
  import sdTxPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int SVC_WORDS  = 8,
  parameter int LEN_W      = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [3:0]        blkSizeCode,
  input  logic [LEN_W-1:0]  xferWords,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  txStrobe_t         stb,
  output logic              fifoEmpty,
  output logic              nibLast,
  output logic              blkLast,
  output logic              crcLast,
  output logic              dataZero,
  output logic              dataReq,
  output logic [3:0]        sendNib,
  output logic [3:0]        crcNib,
  output logic [LEN_W-1:0]  dataCount
);
  localparam int NIB_PER_WORD = WORD_W / 4;
  localparam int PTR_W  = $clog2(FIFO_DEPTH);
  localparam int FCNT_W = $clog2(FIFO_DEPTH + 1);
  localparam int SEQ_W  = (NIB_PER_WORD > 16) ? $clog2(NIB_PER_WORD) : 4;
  localparam int CRC_BITS = 16;

  logic [WORD_W-1:0] mem [FIFO_DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic [FCNT_W-1:0] fill;
  logic [LEN_W-1:0]  pushLeft, dataCnt, blkCnt, blockWords;
  logic [WORD_W-1:0] sh;
  logic [SEQ_W-1:0]  seqCnt;
  logic              wrOk, pop;

  always_comb begin
    if (blkSizeCode < 4'd2) blockWords = LEN_W'(1);
    else                    blockWords = LEN_W'(1) << (blkSizeCode - 4'd2);
  end

  assign fifoEmpty = (fill == '0);
  assign pop       = stb.loadWord;
  assign wrOk      = en && wrEn && (int'(fill) < FIFO_DEPTH) && (pushLeft != '0);
  assign dataReq   = en && ((FIFO_DEPTH - int'(fill)) >= SVC_WORDS) && (pushLeft != '0);

  always_ff @(posedge clk) begin
    if (wrOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0; rdPtr <= '0; fill <= '0; pushLeft <= '0; dataCnt <= '0;
    end else if (!en) begin
      wrPtr <= '0; rdPtr <= '0; fill <= '0;
      pushLeft <= xferWords; dataCnt <= xferWords;
    end else begin
      if (wrOk) begin
        wrPtr    <= (int'(wrPtr) == FIFO_DEPTH - 1) ? '0 : wrPtr + 1'b1;
        pushLeft <= pushLeft - 1'b1;
      end
      if (pop) rdPtr <= (int'(rdPtr) == FIFO_DEPTH - 1) ? '0 : rdPtr + 1'b1;
      fill <= fill + FCNT_W'(wrOk) - FCNT_W'(pop);
      if (stb.wordDone) dataCnt <= dataCnt - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sh <= '0; seqCnt <= '0; blkCnt <= '0;
    end else begin
      if (stb.loadWord)      sh <= mem[rdPtr];
      else if (stb.shiftNib) sh <= {sh[WORD_W-5:0], 4'b0000};
      if (stb.loadWord || stb.clrCnt)        seqCnt <= '0;
      else if (stb.shiftNib || stb.shiftCrc) seqCnt <= seqCnt + 1'b1;
      if (stb.startBlk)      blkCnt <= blockWords;
      else if (stb.wordDone) blkCnt <= blkCnt - 1'b1;
    end
  end

  for (genvar l = 0; l < 4; l++) begin : g_line
    logic [CRC_BITS-1:0] crcQ;
    logic                fb;
    assign fb = sh[WORD_W-4+l] ^ crcQ[CRC_BITS-1];
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)             crcQ <= '0;
      else if (stb.startBlk) crcQ <= '0;
      else if (stb.shiftNib) crcQ <= {crcQ[CRC_BITS-2:0], 1'b0} ^ (fb ? 16'h1021 : 16'h0000);
      else if (stb.shiftCrc) crcQ <= {crcQ[CRC_BITS-2:0], 1'b0};
    end
    assign crcNib[l] = crcQ[CRC_BITS-1];
  end

  assign sendNib   = sh[WORD_W-1 -: 4];
  assign nibLast   = (int'(seqCnt) == NIB_PER_WORD - 1);
  assign crcLast   = (int'(seqCnt) == CRC_BITS - 1);
  assign blkLast   = (blkCnt == LEN_W'(1)) || (dataCnt == LEN_W'(1));
  assign dataZero  = (dataCnt == '0);
  assign dataCount = dataCnt;
endmodule

// File: rtl/sdTxControl.sv
module sdTxControl
  import sdTxPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       en,
  input  logic       dat0In,
  input  logic       fifoEmpty,
  input  logic       nibLast,
  input  logic       blkLast,
  input  logic       crcLast,
  input  logic       dataZero,
  input  logic [3:0] sendNib,
  input  logic [3:0] crcNib,
  output txStrobe_t  stb,
  output logic [3:0] datOut,
  output logic       datOe,
  output logic       txActive,
  output logic       blockEnd,
  output logic       dataEnd,
  output logic       underrun
);
  txState_e state, nextState;

  always_comb begin
    nextState = state;
    stb = '0;
    if (!en) nextState = ST_IDLE;
    else begin
      unique case (state)
        ST_IDLE: nextState = ST_WAIT;
        ST_WAIT: if (!fifoEmpty && dat0In) begin
          stb.startBlk = 1'b1;
          stb.loadWord = 1'b1;
          nextState    = ST_SEND;
        end
        ST_SEND: begin
          stb.shiftNib = 1'b1;
          if (nibLast) begin
            stb.wordDone = 1'b1;
            if (blkLast) begin
              stb.clrCnt = 1'b1;
              nextState  = ST_CRC;
            end else if (fifoEmpty) nextState = ST_FAULT;
            else stb.loadWord = 1'b1;
          end
        end
        ST_CRC: begin
          stb.shiftCrc = 1'b1;
          if (crcLast) nextState = ST_END;
        end
        ST_END:   nextState = dataZero ? ST_DONE : ST_WAIT;
        ST_DONE:  nextState = ST_DONE;
        ST_FAULT: nextState = ST_FAULT;
        default:  nextState = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    unique case (state)
      ST_SEND: datOut = sendNib;
      ST_CRC:  datOut = crcNib;
      default: datOut = 4'hF;
    endcase
  end

  assign datOe    = (state == ST_SEND) || (state == ST_CRC) || (state == ST_END);
  assign txActive = en && (state != ST_DONE) && (state != ST_FAULT);
  assign blockEnd = (state == ST_END);
  assign dataEnd  = (state == ST_DONE);
  assign underrun = (state == ST_FAULT);
endmodule

// File: rtl/sdTxPath.sv
module sdTxPath
  import sdTxPkg::*;
#(
  parameter int WORD_W     = 32,
  parameter int FIFO_DEPTH = 32,
  parameter int SVC_WORDS  = 8,
  parameter int LEN_W      = 14
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              en,
  input  logic [3:0]        blkSizeCode,
  input  logic [LEN_W-1:0]  xferWords,
  input  logic              wrEn,
  input  logic [WORD_W-1:0] wrData,
  input  logic              dat0In,
  output logic              dataReq,
  output logic [3:0]        datOut,
  output logic              datOe,
  output logic              txActive,
  output logic              blockEnd,
  output logic              dataEnd,
  output logic              underrun,
  output logic [LEN_W-1:0]  dataCount
);
  txStrobe_t  stb;
  logic       fifoEmpty, nibLast, blkLast, crcLast, dataZero;
  logic [3:0] sendNib, crcNib;

  sdTxDatapath #(
    .WORD_W(WORD_W), .FIFO_DEPTH(FIFO_DEPTH), .SVC_WORDS(SVC_WORDS), .LEN_W(LEN_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .en(en), .blkSizeCode(blkSizeCode), .xferWords(xferWords),
    .wrEn(wrEn), .wrData(wrData), .stb(stb), .fifoEmpty(fifoEmpty), .nibLast(nibLast),
    .blkLast(blkLast), .crcLast(crcLast), .dataZero(dataZero), .dataReq(dataReq),
    .sendNib(sendNib), .crcNib(crcNib), .dataCount(dataCount)
  );

  sdTxControl u_ctl (
    .clk(clk), .rstN(rstN), .en(en), .dat0In(dat0In), .fifoEmpty(fifoEmpty),
    .nibLast(nibLast), .blkLast(blkLast), .crcLast(crcLast), .dataZero(dataZero),
    .sendNib(sendNib), .crcNib(crcNib), .stb(stb), .datOut(datOut), .datOe(datOe),
    .txActive(txActive), .blockEnd(blockEnd), .dataEnd(dataEnd), .underrun(underrun)
  );
endmodule

// File: rtl/sdTxPathChk.sv
module sdTxPathChk #(
  parameter int LEN_W = 14
) (
  input logic             clk,
  input logic             rstN,
  input logic             en,
  input logic             dataReq,
  input logic [3:0]       datOut,
  input logic             datOe,
  input logic             txActive,
  input logic             blockEnd,
  input logic             dataEnd,
  input logic             underrun,
  input logic [LEN_W-1:0] dataCount
);
  // R9
  oe_needs_active_chk: assert property (@(posedge clk) disable iff (!rstN)
    datOe |-> txActive);
  // R9
  idle_lines_chk: assert property (@(posedge clk) disable iff (!rstN)
    !datOe |-> datOut == 4'hF);
  // R6
  end_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataEnd |-> dataCount == '0);
  // R6
  count_mono_chk: assert property (@(posedge clk) disable iff (!rstN)
    (en && $past(en)) |-> dataCount <= $past(dataCount));
  // R8
  fault_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    underrun |-> (!datOe && !dataEnd));
  // R5
  end_bit_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |-> (datOe && datOut == 4'hF));
  // R5
  after_end_chk: assert property (@(posedge clk) disable iff (!rstN)
    blockEnd |=> !datOe);
  // R2
  req_en_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataReq |-> en);
  // R1
  disable_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> !datOe);
endmodule

bind sdTxPath sdTxPathChk #(.LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .en(en), .dataReq(dataReq), .datOut(datOut), .datOe(datOe),
  .txActive(txActive), .blockEnd(blockEnd), .dataEnd(dataEnd), .underrun(underrun),
  .dataCount(dataCount)
);

// File: tb/sdTxPath_bench.sv
module sdTxPath_bench;
  localparam int LEN_W = 14;

  logic clk = 1'b0, rstN = 1'b0, en = 1'b0, wrEn = 1'b0, dat0In = 1'b1;
  logic [3:0] blkSizeCode = 4'd4;
  logic [LEN_W-1:0] xferWords = '0;
  logic [31:0] wrData = '0;
  logic dataReq, datOe, txActive, blockEnd, dataEnd, underrun;
  logic [3:0] datOut;
  logic [LEN_W-1:0] dataCount;

  int nChk = 0, nBad = 0;
  bit finished = 0;
  logic [3:0] cap[$];
  int beCnt = 0;

  always #5 clk = ~clk;

  sdTxPath #(.LEN_W(LEN_W)) u_sdTxPath (
    .clk(clk), .rstN(rstN), .en(en), .blkSizeCode(blkSizeCode), .xferWords(xferWords),
    .wrEn(wrEn), .wrData(wrData), .dat0In(dat0In), .dataReq(dataReq), .datOut(datOut),
    .datOe(datOe), .txActive(txActive), .blockEnd(blockEnd), .dataEnd(dataEnd),
    .underrun(underrun), .dataCount(dataCount)
  );

  always @(negedge clk) begin
    if (datOe) cap.push_back(datOut);
    if (blockEnd) beCnt++;
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint expv);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
    end
  endtask

  function automatic logic [31:0] wordOf(input logic [31:0] seed, input int i);
    return (32'h9E3779B9 * (i + 1)) ^ seed;
  endfunction

  // Build the expected line stream (R3, R4, R5) and compare with capture.
  task automatic cmpStream(input int base, input int nWords, input int bw,
                           input logic [31:0] seed, input string tag);
    logic [3:0] exp[$];
    int idx = 0;
    bit ok = 1;
    while (idx < nWords) begin
      logic [15:0] crc [4];
      for (int l = 0; l < 4; l++) crc[l] = 16'h0;
      for (int k = 0; k < bw && idx < nWords; k++) begin
        logic [31:0] w = wordOf(seed, idx);
        for (int n = 7; n >= 0; n--) begin
          logic [3:0] nib = w[n*4 +: 4];
          exp.push_back(nib);
          for (int l = 0; l < 4; l++) begin
            logic b = nib[l] ^ crc[l][15];
            crc[l] = {crc[l][14:0], 1'b0} ^ (b ? 16'h1021 : 16'h0000);
          end
        end
        idx++;
      end
      for (int c = 15; c >= 0; c--)
        exp.push_back({crc[3][c], crc[2][c], crc[1][c], crc[0][c]});
      exp.push_back(4'hF);
    end
    chk(cap.size() - base == exp.size(), {tag, " stream length"}, cap.size() - base, exp.size());
    for (int i = 0; i < exp.size() && ok; i++) begin
      if (base + i >= cap.size() || cap[base + i] !== exp[i]) begin
        ok = 0;
        $display("FAIL %s nibble %0d: actual %h expected %h", tag, i,
                 (base + i < cap.size()) ? cap[base + i] : 4'hx, exp[i]);
      end
    end
    nChk++;
    if (!ok) nBad++;
  endtask

  task automatic runXfer(input int code, input int nWords, input logic [31:0] seed,
                         input bit busyStart, input bit busyMid);
    int base, beBase, svc = 0, bw, oeBusy = 0, guard = 0;
    bw = (code < 2) ? 1 : (1 << (code - 2));
    en = 0; blkSizeCode = 4'(code); xferWords = LEN_W'(nWords);
    repeat (2) @(negedge clk);
    base = cap.size(); beBase = beCnt;
    if (busyStart) dat0In = 0;
    en = 1;
    fork
      begin : feeder
        int pushed = 0;
        while (pushed < nWords) begin
          @(negedge clk);
          if (dataReq) begin
            svc++;
            for (int k = 0; k < 8 && pushed < nWords; k++) begin
              wrEn = 1; wrData = wordOf(seed, pushed); pushed++;
              @(negedge clk);
            end
            wrEn = 0;
          end
        end
      end
      begin : busyGen
        if (busyStart) begin
          repeat (40) begin @(negedge clk); if (datOe) oeBusy++; end
          dat0In = 1;
        end
        if (busyMid) begin
          @(negedge clk);
          while (!blockEnd) @(negedge clk);
          dat0In = 0;
          repeat (40) begin @(negedge clk); if (datOe) oeBusy++; end
          dat0In = 1;
        end
      end
    join
    while (!dataEnd && !underrun && guard < 40000) begin @(negedge clk); guard++; end
    chk(oeBusy == 0, "R7 no drive while DAT0 low at block start", oeBusy, 0);
    chk(svc == (nWords + 7) / 8, "R2 request count", svc, (nWords + 7) / 8);
    chk(dataEnd == 1, "R6 dataEnd after last block", dataEnd, 1);
    chk(dataCount == 0, "R6 dataCount at end", dataCount, 0);
    chk(txActive == 0, "R9 txActive low after final end bit", txActive, 0);
    chk(dataReq == 0, "R2 request masked once length is covered", dataReq, 0);
    chk(beCnt - beBase == (nWords + bw - 1) / bw, "R5 blockEnd pulses",
        beCnt - beBase, (nWords + bw - 1) / bw);
    cmpStream(base, nWords, bw, seed, "R3/R4/R5 stream");
    en = 0;
    @(negedge clk);
    chk(dataEnd == 0 && txActive == 0, "R6 status cleared by disable", dataEnd, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChk++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    chk(datOe == 0 && datOut == 4'hF, "R10 reset lines", datOut, 15);
    chk(!dataReq && !txActive && !blockEnd && !dataEnd && !underrun, "R10 reset status",
        {dataReq, txActive, blockEnd, dataEnd, underrun}, 0);
    rstN = 1;
    @(negedge clk);

    // R1: writes while disabled are dropped; FIFO stays empty after enable.
    xferWords = LEN_W'(6); blkSizeCode = 4'd4;
    @(negedge clk);
    chk(dataReq == 0, "R2 no request while disabled", dataReq, 0);
    for (int i = 0; i < 3; i++) begin wrEn = 1; wrData = 32'hA5A5_0000 + i; @(negedge clk); end
    wrEn = 0;
    begin
      int oe = 0;
      en = 1;
      repeat (30) begin @(negedge clk); if (datOe) oe++; end
      chk(oe == 0, "R1 preloaded words not sent", oe, 0);
      chk(dataCount == 6, "R6 dataCount loaded", dataCount, 6);
      chk(txActive == 1, "R9 txActive while waiting", txActive, 1);
      chk(dataReq == 1, "R2 request when empty and words owed", dataReq, 1);
    end
    en = 0;
    @(negedge clk);
    chk(txActive == 0, "R9 txActive low when disabled", txActive, 0);

    // Transfer sweep: block size codes and lengths incl. partial last block (R4).
    runXfer(4, 4, 32'h1234_5678, 0, 0);
    runXfer(4, 16, 32'hDEAD_BEEF, 0, 0);
    runXfer(5, 10, 32'h0F0F_F0F0, 0, 0);
    runXfer(9, 128, 32'hC001_D00D, 0, 0);   // R2: 512 bytes -> 16 requests
    runXfer(9, 256, 32'h5555_AAAA, 0, 1);   // R7 busy between blocks
    runXfer(5, 24, 32'h0000_0001, 1, 0);    // R7 busy at start
    runXfer(6, 1, 32'hFFFF_0000, 0, 0);
    runXfer(0, 3, 32'h1357_9BDF, 0, 0);

    // R8 underrun: 16-word block, only two words supplied.
    begin
      int base, guard = 0;
      en = 0; blkSizeCode = 4'd6; xferWords = LEN_W'(16);
      repeat (2) @(negedge clk);
      base = cap.size();
      en = 1;
      @(negedge clk);
      wrEn = 1; wrData = wordOf(32'h7777_0000, 0); @(negedge clk);
      wrData = wordOf(32'h7777_0000, 1); @(negedge clk);
      wrEn = 0;
      while (!underrun && guard < 200) begin @(negedge clk); guard++; end
      chk(underrun == 1, "R8 underrun flagged", underrun, 1);
      chk(dataCount == 14, "R8 dataCount holds unsent words", dataCount, 14);
      chk(txActive == 0, "R8 txActive low after underrun", txActive, 0);
      repeat (10) @(negedge clk);
      chk(cap.size() - base == 16, "R8 only two words driven", cap.size() - base, 16);
      chk(datOe == 0 && dataEnd == 0, "R8 lines quiet, no dataEnd", datOe, 0);
      en = 0;
      @(negedge clk);
      chk(underrun == 0, "R8 underrun cleared by disable", underrun, 0);
    end

    finished = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", nChk, nBad);
    $finish;
  end
endmodule